// File: doc/BRIEF.md
# Quadratic-Recurrence Bin Parameter Generator

This block feeds a bank of time-multiplexed sinusoidal oscillators with the three parameters of each bin: a frequency word, a phase offset word and an amplitude. It stores no per-bin table. On every clock it advances a set of accumulators by one bin. Frequency and phase follow second-order difference recurrences, so they are quadratic in the bin index k. The amplitude is a running product whose per-bin factor itself changes geometrically, which gives a Gaussian-like envelope across the block.

A start pulse, issued once per sample period, loads every accumulator from the input ports and resets k to 0. The block then presents bins 0 to N-1 on consecutive cycles with a valid flag. After that it stays idle until the next start. The input ports may change at any time. Only the values present during the start cycle govern a run, because they are captured into working registers at that edge. The host computes the exponential factors and supplies them as fixed-point words.

Top module: `bin_param_gen`

## Requirements
- R1: In the cycle after a start pulse with N ≥ 1, valid is 1, the index is 0, the frequency equals the start-cycle initial frequency, the phase equals the initial phase and the amplitude equals the initial amplitude.
- R2: While a run is in progress the index rises by exactly one per clock. Valid stays high for exactly N consecutive cycles (N up to 2048, given on a 12-bit port) and then stays low until the next start.
- R3: The frequency follows f(k+1) = f(k) + (step + curv) + 2·curv·k, computed modulo 2^32.
- R4: The phase follows p(k+1) = p(k) + (step + curv) + 2·curv·k using the phase step and curvature inputs, computed modulo 2^32.
- R5: The amplitude is unsigned Q1.26 in 27 bits. The three factor inputs are unsigned Q3.24 in 27 bits. The per-bin factor starts as c(0) = decay·shape_init >> 24. Each step then gives A(k+1) = A(k)·c(k) >> 24 and c(k+1) = c(k)·shape_ratio >> 24, with each product truncated.
- R6: Any amplitude or factor product that exceeds 2^27-1 saturates to 2^27-1.
- R7: Changes to any parameter input between start pulses have no effect on the run in progress.
- R8: A start pulse during a run abandons that run and restarts at index 0 with the new parameters.
- R9: A start pulse with N = 0 produces no valid cycle.
- R10: After reset, valid is 0 and the index, frequency, phase and amplitude outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; loads all state |
| nbins_i | input | 12 | Bins per run, 0 to 2048 |
| freq_init_i | input | 32 | Frequency of bin 0 |
| freq_step_i | input | 32 | Linear frequency step |
| freq_curv_i | input | 32 | Frequency curvature |
| phase_init_i | input | 32 | Phase offset of bin 0 |
| phase_step_i | input | 32 | Linear phase step |
| phase_curv_i | input | 32 | Phase curvature |
| amp_init_i | input | 27 | Amplitude of bin 0, Q1.26 |
| amp_decay_i | input | 27 | Constant decay factor, Q3.24 |
| amp_shape_init_i | input | 27 | Initial envelope factor, Q3.24 |
| amp_shape_ratio_i | input | 27 | Per-bin envelope ratio, Q3.24 |
| bin_valid_o | output | 1 | Outputs carry a bin |
| bin_idx_o | output | 11 | Bin index k |
| freq_o | output | 32 | Frequency of bin k |
| phase_o | output | 32 | Phase offset of bin k |
| amp_o | output | 27 | Amplitude of bin k, Q1.26 |

## Verification
The hardest situations to reach are the ones that only show up deep in a long run. These are the last index of a full 2048-bin run, a wrap of the modular accumulators, and a saturating amplitude that must then stay pinned. The stimulus reaches them with directed runs. One run uses the full bin count. One starts the frequency just below 2^32 with a large step. One starts the amplitude near its ceiling and applies a factor of two. Randomized runs scramble every parameter port on each cycle of a run to show that the captured copies are used. One run is cut short by a second start so that the restart path is exercised from the middle of a run.

// File: rtl/bin_param_pkg.sv
package bin_param_pkg;
  localparam int unsigned ACC_W_DEF  = 32;
  localparam int unsigned AMP_W_DEF  = 27;
  localparam int unsigned FAC_W_DEF  = 27;
  localparam int unsigned FAC_FR_DEF = 24;
  localparam int unsigned IDX_W_DEF  = 11;
endpackage

// File: rtl/bin_seq_ctrl.sv
module bin_seq_ctrl #(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W:0]   nbins_i,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             step_o
);
  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W:0]   last_full;
  logic             at_last;

  assign last_full = nbins_i - 1'b1;
  assign at_last   = (idx_q == last_q);
  assign step_o    = run_q && !at_last && !start_i;

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (start_i) begin
      run_d  = (nbins_i != '0);
      idx_d  = '0;
      last_d = last_full[IDX_W-1:0];
    end else if (run_q) begin
      if (at_last) run_d = 1'b0;
      else         idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign run_o = run_q;
  assign idx_o = idx_q;

  // R2
  last_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_last && !start_i) |=> !run_q);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (run_q && idx_q == $past(idx_q) + 1'b1));
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && nbins_i == '0) |=> !run_q);
endmodule

// File: rtl/bin_diff_accum.sv
module bin_diff_accum #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] init_i,
  input  logic [W-1:0] lin_i,
  input  logic [W-1:0] curv_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] dif_q, dif_d;
  logic [W-1:0] inc_q, inc_d;

  always_comb begin
    acc_d = acc_q;
    dif_d = dif_q;
    inc_d = inc_q;
    if (load_i) begin
      acc_d = init_i;
      dif_d = lin_i + curv_i;
      inc_d = curv_i << 1;
    end else if (step_i) begin
      acc_d = acc_q + dif_q;
      dif_d = dif_q + inc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dif_q <= '0;
      inc_q <= '0;
    end else begin
      acc_q <= acc_d;
      dif_q <= dif_d;
      inc_q <= inc_d;
    end
  end

  assign acc_o = acc_q;

  // R7
  accum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/bin_sat_mul.sv
module bin_sat_mul #(
  parameter int unsigned AW = 27,
  parameter int unsigned BW = 27,
  parameter int unsigned OW = 27,
  parameter int unsigned SH = 24
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [OW-1:0] p_o
);
  localparam int unsigned PW = AW + BW;
  logic [PW-1:0] prod;
  logic [PW-1:0] shifted;
  logic          ovf;

  always_comb begin
    prod    = PW'(a_i) * PW'(b_i);
    shifted = prod >> SH;
    ovf     = |(shifted >> OW);
    p_o     = ovf ? {OW{1'b1}} : shifted[OW-1:0];
  end
endmodule

// File: rtl/bin_param_gen.sv
module bin_param_gen
  import bin_param_pkg::*;
#(
  parameter int unsigned ACC_W  = ACC_W_DEF,
  parameter int unsigned AMP_W  = AMP_W_DEF,
  parameter int unsigned FAC_W  = FAC_W_DEF,
  parameter int unsigned FAC_FR = FAC_FR_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W:0]   nbins_i,
  input  logic [ACC_W-1:0] freq_init_i,
  input  logic [ACC_W-1:0] freq_step_i,
  input  logic [ACC_W-1:0] freq_curv_i,
  input  logic [ACC_W-1:0] phase_init_i,
  input  logic [ACC_W-1:0] phase_step_i,
  input  logic [ACC_W-1:0] phase_curv_i,
  input  logic [AMP_W-1:0] amp_init_i,
  input  logic [FAC_W-1:0] amp_decay_i,
  input  logic [FAC_W-1:0] amp_shape_init_i,
  input  logic [FAC_W-1:0] amp_shape_ratio_i,
  output logic             bin_valid_o,
  output logic [IDX_W-1:0] bin_idx_o,
  output logic [ACC_W-1:0] freq_o,
  output logic [ACC_W-1:0] phase_o,
  output logic [AMP_W-1:0] amp_o
);
  localparam int unsigned N_ACC = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic step;
  bin_seq_ctrl #(.IDX_W(IDX_W)) seq_i (
    .clk    (clk),
    .rst_n  (rst_s),
    .start_i(start_i),
    .nbins_i(nbins_i),
    .run_o  (bin_valid_o),
    .idx_o  (bin_idx_o),
    .step_o (step)
  );

  // frequency and phase share one accumulator structure
  logic [ACC_W-1:0] acc_init [N_ACC];
  logic [ACC_W-1:0] acc_lin  [N_ACC];
  logic [ACC_W-1:0] acc_curv [N_ACC];
  logic [ACC_W-1:0] acc_val  [N_ACC];

  assign acc_init[0] = freq_init_i;
  assign acc_lin[0]  = freq_step_i;
  assign acc_curv[0] = freq_curv_i;
  assign acc_init[1] = phase_init_i;
  assign acc_lin[1]  = phase_step_i;
  assign acc_curv[1] = phase_curv_i;

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    bin_diff_accum #(.W(ACC_W)) acc_i (
      .clk   (clk),
      .rst_n (rst_s),
      .load_i(start_i),
      .step_i(step),
      .init_i(acc_init[g]),
      .lin_i (acc_lin[g]),
      .curv_i(acc_curv[g]),
      .acc_o (acc_val[g])
    );
  end

  assign freq_o  = acc_val[0];
  assign phase_o = acc_val[1];

  // amplitude: running product with a geometrically changing factor
  logic [AMP_W-1:0] amp_q, amp_d, amp_prod;
  logic [FAC_W-1:0] fac_q, fac_d, fac_prod;
  logic [FAC_W-1:0] ratio_q, ratio_d;
  logic [FAC_W-1:0] fm_a, fm_b;

  assign fm_a = start_i ? amp_decay_i      : fac_q;
  assign fm_b = start_i ? amp_shape_init_i : ratio_q;

  bin_sat_mul #(.AW(FAC_W), .BW(FAC_W), .OW(FAC_W), .SH(FAC_FR)) fac_mul_i (
    .a_i(fm_a),
    .b_i(fm_b),
    .p_o(fac_prod)
  );

  bin_sat_mul #(.AW(AMP_W), .BW(FAC_W), .OW(AMP_W), .SH(FAC_FR)) amp_mul_i (
    .a_i(amp_q),
    .b_i(fac_q),
    .p_o(amp_prod)
  );

  always_comb begin
    amp_d   = amp_q;
    fac_d   = fac_q;
    ratio_d = ratio_q;
    if (start_i) begin
      amp_d   = amp_init_i;
      fac_d   = fac_prod;
      ratio_d = amp_shape_ratio_i;
    end else if (step) begin
      amp_d = amp_prod;
      fac_d = fac_prod;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      amp_q   <= '0;
      fac_q   <= '0;
      ratio_q <= '0;
    end else begin
      amp_q   <= amp_d;
      fac_q   <= fac_d;
      ratio_q <= ratio_d;
    end
  end

  assign amp_o = amp_q;

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (start_i && nbins_i != '0) |=> (bin_valid_o && bin_idx_o == '0 &&
      freq_o == $past(freq_init_i) && phase_o == $past(phase_init_i) &&
      amp_o == $past(amp_init_i)));
  // R6
  amp_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (step && amp_q == {AMP_W{1'b1}} && fac_q >= (FAC_W'(1) << FAC_FR)) |=>
      amp_q == {AMP_W{1'b1}});
endmodule

// File: tb/bin_param_gen_tb.sv
module bin_param_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [26:0] MAXV = 27'h7FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] nbins;
  logic [31:0] f0, fs, fc, p0, ps, pc;
  logic [26:0] a0, dec, gi, gr;
  logic        vld;
  logic [10:0] idx;
  logic [31:0] fo, po;
  logic [26:0] ao;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [31:0] m_f, m_df, m_2a, m_p, m_dp, m_2p;
  logic [26:0] m_a, m_c, m_r;
  int          m_k, m_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_param_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nbins_i(nbins),
    .freq_init_i(f0), .freq_step_i(fs), .freq_curv_i(fc),
    .phase_init_i(p0), .phase_step_i(ps), .phase_curv_i(pc),
    .amp_init_i(a0), .amp_decay_i(dec), .amp_shape_init_i(gi),
    .amp_shape_ratio_i(gr),
    .bin_valid_o(vld), .bin_idx_o(idx), .freq_o(fo), .phase_o(po), .amp_o(ao)
  );

  function automatic logic [26:0] mmul(input logic [26:0] a, input logic [26:0] b);
    logic [63:0] p;
    p = (64'(a) * 64'(b)) >> 24;
    return (p > 64'(MAXV)) ? MAXV : p[26:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (k=%0d)", tag, act, exp, m_k);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic scramble();
    f0 = $urandom; fs = $urandom; fc = $urandom;
    p0 = $urandom; ps = $urandom; pc = $urandom;
    a0 = 27'($urandom); dec = 27'($urandom); gi = 27'($urandom); gr = 27'($urandom);
    nbins = 12'($urandom);
  endtask

  // called at a falling edge; returns at the falling edge where bin 0 shows
  task automatic do_start(input logic [31:0] if0, ifs, ifc, ip0, ips, ipc,
                          input logic [26:0] ia0, idec, igi, igr, input int n);
    f0 = if0; fs = ifs; fc = ifc; p0 = ip0; ps = ips; pc = ipc;
    a0 = ia0; dec = idec; gi = igi; gr = igr; nbins = 12'(n);
    start = 1'b1;
    m_f = if0; m_df = ifs + ifc; m_2a = ifc << 1;
    m_p = ip0; m_dp = ips + ipc; m_2p = ipc << 1;
    m_a = ia0; m_c = mmul(idec, igi); m_r = igr;
    m_k = 0; m_n = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_bin();
    chk("R2 valid", 64'(vld), 64'd1);
    chk("R2 index", 64'(idx), 64'(m_k));
    chk("R3 freq", 64'(fo), 64'(m_f));
    chk("R4 phase", 64'(po), 64'(m_p));
    chk("R5 amp", 64'(ao), 64'(m_a));
    m_f = m_f + m_df; m_df = m_df + m_2a;
    m_p = m_p + m_dp; m_dp = m_dp + m_2p;
    m_a = mmul(m_a, m_c); m_c = mmul(m_c, m_r);
    m_k++;
  endtask

  task automatic run_rest(input bit scr);
    while (m_k < m_n) begin
      check_bin();
      if (scr) scramble();
      @(negedge clk);
    end
    chk("R2 valid after last bin", 64'(vld), 64'd0);
    @(negedge clk);
    chk("R2 stays idle", 64'(vld), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0;
    f0 = '0; fs = '0; fc = '0; p0 = '0; ps = '0; pc = '0;
    a0 = '0; dec = '0; gi = '0; gr = '0; nbins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10
    chk("R10 valid", 64'(vld), 64'd0);
    chk("R10 index", 64'(idx), 64'd0);
    chk("R10 freq", 64'(fo), 64'd0);
    chk("R10 phase", 64'(po), 64'd0);
    chk("R10 amp", 64'(ao), 64'd0);

    // R1 simple run: unit factors
    do_start(32'd100, 32'd10, 32'd3, 32'd7, 32'd5, 32'd1,
             27'h100_0000, 27'h100_0000, 27'h100_0000, 27'h100_0000, 5);
    chk("R1 freq bin0", 64'(fo), 64'd100);
    chk("R1 amp bin0", 64'(ao), 64'h100_0000);
    run_rest(1'b0);

    // R3 R4 wrap: near top of the modular range
    do_start(32'hFFFF_FFF0, 32'h4000_0000, 32'h1000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
             32'h7FFF_FFFF, 27'h080_0000, 27'h0F0_0000, 27'h120_0000, 27'h0E0_0000, 9);
    run_rest(1'b0);

    // R6 saturation: factor of two from near the ceiling
    do_start(32'd0, 32'd1, 32'd0, 32'd0, 32'd1, 32'd0,
             MAXV - 27'd100, 27'h200_0000, 27'h100_0000, 27'h100_0000, 4);
    @(negedge clk);
    chk("R6 amp saturated", 64'(ao), 64'(MAXV));
    @(negedge clk);
    chk("R6 amp stays saturated", 64'(ao), 64'(MAXV));
    repeat (3) @(negedge clk);

    // R9 zero-length run
    do_start(32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1,
             27'd1, 27'd1, 27'd1, 27'd1, 0);
    chk("R9 no valid", 64'(vld), 64'd0);
    @(negedge clk);
    chk("R9 still no valid", 64'(vld), 64'd0);

    // R8 restart in the middle of a run
    do_start(32'd5, 32'd6, 32'd7, 32'd8, 32'd9, 32'd10,
             27'h0C0_0000, 27'h0FF_0000, 27'h101_0000, 27'h0FE_0000, 10);
    check_bin(); @(negedge clk);
    check_bin(); @(negedge clk);
    do_start(32'h1234_5678, 32'd77, 32'd2, 32'h2222, 32'd3, 32'd4,
             27'h050_0000, 27'h110_0000, 27'h0F0_0000, 27'h101_0000, 3);
    chk("R8 restart index", 64'(idx), 64'd0);
    chk("R8 restart freq", 64'(fo), 64'h1234_5678);
    run_rest(1'b0);

    // R2 full-length run, R7 ports scrambled every cycle
    do_start($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             27'h0FF_FFFF, 27'h0FF_F000, 27'h100_0000, 27'h100_0000, 2048);
    run_rest(1'b1);

    // randomized runs, R7 scrambling on alternate runs
    for (int r = 0; r < 30; r++) begin
      do_start($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
               27'($urandom), 27'h0E0_0000 + 27'($urandom_range(0, 32'h40_0000)),
               27'h0F0_0000 + 27'($urandom_range(0, 32'h20_0000)),
               27'h0F8_0000 + 27'($urandom_range(0, 32'h10_0000)),
               int'($urandom_range(1, 60)));
      run_rest(r[0]);
    end

    summary();
  end
endmodule